// File: doc/BRIEF.md
# Congestion-Ordered Multicast Port Sequencer

This block decides the order in which the output ports named in a multicast destination mask each get a copy of a packet. Each output port has a queued-packet count and a media speed code. From these the block forms a congestion weight that estimates how long that port needs to drain its queue. It serves the port with the smallest weight first. It offers the next port only after the current copy has been reported as transmitted, and it recomputes every weight from the counters as they stand at that moment.

The CPU port is always served after every other port in the mask, whatever its weight. The block does not divide: the count is shifted left by an amount set by the speed code, so a slow port weighs more per queued packet. Ties go to the lower port number. When no port is left in the mask, a completion flag rises and stays high until the next packet is loaded. A packet with an empty mask completes at once.

Top module: `mc_port_sequencer`

## Requirements
- R1: After synchronous reset, `sel_valid_o`, `done_o` and `busy_o` are all 0.
- R2: When `start_i` is high while the block is idle, it loads `mask_i`. One cycle later `busy_o` is high. Two cycles after the start edge, `sel_valid_o` is 1 and `sel_port_o` names the eligible port with the smallest weight.
- R3: A port's weight is its count shifted left by a speed-dependent amount: speed code 0 (10 Mb/s) shifts by 6, code 1 (100 Mb/s) by 3, and codes 2 (1 Gb/s) and 3 shift by 0.
- R4: When weights are equal, the lowest port number wins.
- R5: While `sel_valid_o` is high and `tx_done_i` is low, `sel_port_o` and `sel_valid_o` hold their values.
- R6: A `tx_done_i` pulse while `sel_valid_o` is high drops `sel_valid_o` on the next edge. On the edge after that, the next port is chosen from the remaining ports, using the counts and speeds present at that edge.
- R7: Every port in the loaded mask is offered exactly once, and no port outside the mask is ever offered.
- R8: The CPU port (the highest port number, NPORT-1) is offered only after all other ports in the mask, even when its weight is the smallest.
- R9: `done_o` rises one cycle after the selection step that finds no port left. For an empty mask, that is two edges after start. `done_o` stays high, with `sel_valid_o` low, until the next accepted start.
- R10: `start_i` is ignored while `busy_o` is high. `tx_done_i` is ignored while `sel_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Load a new destination mask (taken only when idle) |
| mask_i | input | NPORT | Destination port mask; bit NPORT-1 is the CPU port |
| q_count_i | input | NPORT*CNT_W | Per-port queued packet counts, port p at bits [p*CNT_W +: CNT_W] |
| speed_i | input | NPORT*2 | Per-port speed codes, port p at bits [p*2 +: 2] |
| tx_done_i | input | 1 | Current copy transmitted; advance to next port |
| sel_valid_o | output | 1 | A port is currently offered |
| sel_port_o | output | $clog2(NPORT) | Offered port number |
| busy_o | output | 1 | A mask is being sequenced |
| done_o | output | 1 | All ports of the last mask have been served |

## Verification
The bench builds the block with its defaults: eight ports, with port 7 as the CPU port, and 10-bit counts. With these values the 6-bit shift for 10 Mb/s ports produces weights up to 16 bits, so ports of different speeds can be made to collide or to overtake each other. Random counts are redrawn between steps, so the recomputation at each step is exercised. Directed cases cover the empty mask, a CPU-only mask, a CPU port with the smallest weight, full ties, and a start or transmit-done pulse that arrives when it must be ignored.

// File: rtl/mc_seq_pkg.sv
package mc_seq_pkg;

    localparam int SPD_W     = 2;
    localparam int MAX_SHIFT = 6;

    typedef enum logic [1:0] {
        SPD_10M  = 2'd0,
        SPD_100M = 2'd1,
        SPD_1G   = 2'd2,
        SPD_RSV  = 2'd3
    } speed_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PICK = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_e;

    // Left shift standing in for division by media speed
    function automatic logic [2:0] speed_shift(input logic [SPD_W-1:0] code);
        case (speed_e'(code))
            SPD_10M:  speed_shift = 3'd6;
            SPD_100M: speed_shift = 3'd3;
            default:  speed_shift = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/mc_cong_weight.sv
module mc_cong_weight
    import mc_seq_pkg::*;
#(
    parameter int NPORT = 8,
    parameter int CNT_W = 10,
    parameter int WGT_W = CNT_W + MAX_SHIFT
) (
    input  logic [NPORT*CNT_W-1:0] q_count_i,
    input  logic [NPORT*SPD_W-1:0] speed_i,
    output logic [NPORT*WGT_W-1:0] wgt_o
);

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        logic [WGT_W-1:0] cnt_ext;
        assign cnt_ext = WGT_W'(q_count_i[g*CNT_W +: CNT_W]);
        assign wgt_o[g*WGT_W +: WGT_W] = cnt_ext << speed_shift(speed_i[g*SPD_W +: SPD_W]);
    end

endmodule

// File: rtl/mc_min_select.sv
module mc_min_select #(
    parameter int NPORT    = 8,
    parameter int WGT_W    = 16,
    parameter int CPU_PORT = NPORT - 1,
    parameter int PW       = $clog2(NPORT)
) (
    input  logic [NPORT-1:0]       rem_i,
    input  logic [NPORT*WGT_W-1:0] wgt_i,
    output logic                   any_o,
    output logic [PW-1:0]          port_o
);

    logic [NPORT-1:0] non_cpu;
    logic [NPORT-1:0] elig;
    logic [WGT_W-1:0] best_w;
    logic             found;

    always_comb begin
        non_cpu           = rem_i;
        non_cpu[CPU_PORT] = 1'b0;
        elig              = (|non_cpu) ? non_cpu : rem_i;
        found             = 1'b0;
        best_w            = '0;
        port_o            = '0;
        for (int i = 0; i < NPORT; i++) begin
            // strict compare keeps the lowest index on a tie
            if (elig[i] && (!found || wgt_i[i*WGT_W +: WGT_W] < best_w)) begin
                found  = 1'b1;
                best_w = wgt_i[i*WGT_W +: WGT_W];
                port_o = PW'(i);
            end
        end
    end

    assign any_o = |rem_i;

endmodule

// File: rtl/mc_seq_ctrl.sv
module mc_seq_ctrl
    import mc_seq_pkg::*;
#(
    parameter int NPORT = 8,
    parameter int PW    = $clog2(NPORT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [NPORT-1:0] mask_i,
    input  logic             tx_done_i,
    input  logic             any_i,
    input  logic [PW-1:0]    pick_i,
    output logic [NPORT-1:0] rem_o,
    output logic             sel_valid_o,
    output logic [PW-1:0]    sel_port_o,
    output logic             busy_o,
    output logic             done_o
);

    seq_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            rem_o       <= '0;
            sel_valid_o <= 1'b0;
            sel_port_o  <= '0;
            done_o      <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        rem_o   <= mask_i;
                        done_o  <= 1'b0;
                        state_q <= ST_PICK;
                    end
                end
                ST_PICK: begin
                    if (!any_i) begin
                        done_o  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        sel_port_o    <= pick_i;
                        sel_valid_o   <= 1'b1;
                        rem_o[pick_i] <= 1'b0;
                        state_q       <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (tx_done_i) begin
                        sel_valid_o <= 1'b0;
                        state_q     <= ST_PICK;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o = (state_q != ST_IDLE);

endmodule

// File: rtl/mc_port_sequencer.sv
module mc_port_sequencer
    import mc_seq_pkg::*;
#(
    parameter int NPORT = 8,
    parameter int CNT_W = 10,
    localparam int PW    = $clog2(NPORT),
    localparam int WGT_W = CNT_W + MAX_SHIFT
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_i,
    input  logic [NPORT-1:0]       mask_i,
    input  logic [NPORT*CNT_W-1:0] q_count_i,
    input  logic [NPORT*SPD_W-1:0] speed_i,
    input  logic                   tx_done_i,
    output logic                   sel_valid_o,
    output logic [PW-1:0]          sel_port_o,
    output logic                   busy_o,
    output logic                   done_o
);

    logic [NPORT*WGT_W-1:0] wgt_w;
    logic [NPORT-1:0]       rem_w;
    logic                   any_w;
    logic [PW-1:0]          pick_w;

    mc_cong_weight #(.NPORT(NPORT), .CNT_W(CNT_W), .WGT_W(WGT_W)) weight_i (
        .q_count_i (q_count_i),
        .speed_i   (speed_i),
        .wgt_o     (wgt_w)
    );

    mc_min_select #(.NPORT(NPORT), .WGT_W(WGT_W), .CPU_PORT(NPORT-1), .PW(PW)) select_i (
        .rem_i  (rem_w),
        .wgt_i  (wgt_w),
        .any_o  (any_w),
        .port_o (pick_w)
    );

    mc_seq_ctrl #(.NPORT(NPORT), .PW(PW)) ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .mask_i      (mask_i),
        .tx_done_i   (tx_done_i),
        .any_i       (any_w),
        .pick_i      (pick_w),
        .rem_o       (rem_w),
        .sel_valid_o (sel_valid_o),
        .sel_port_o  (sel_port_o),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

endmodule

// File: rtl/mc_port_sequencer_chk.sv
module mc_port_sequencer_chk #(
    parameter int NPORT = 8,
    parameter int PW    = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             tx_done_i,
    input logic             sel_valid_o,
    input logic [PW-1:0]    sel_port_o,
    input logic             busy_o,
    input logic             done_o,
    input logic [NPORT-1:0] rem
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!sel_valid_o && !done_o && !busy_o));

    // R5
    hold_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_valid_o && !tx_done_i) |=> (sel_valid_o && $stable(sel_port_o)));

    // R6
    tx_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_valid_o && tx_done_i) |=> !sel_valid_o);

    // R8
    cpu_last_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(sel_valid_o) && sel_port_o == PW'(NPORT-1)) |-> (rem == '0));

    // R9
    done_empty_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!sel_valid_o && rem == '0));

    // R10
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && sel_valid_o && !tx_done_i) |=> $stable(sel_port_o));

endmodule

bind mc_port_sequencer mc_port_sequencer_chk #(.NPORT(NPORT), .PW(PW)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .tx_done_i   (tx_done_i),
    .sel_valid_o (sel_valid_o),
    .sel_port_o  (sel_port_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .rem         (rem_w)
);

// File: tb/mc_port_sequencer_tb_top.sv
`timescale 1ns/1ps
module mc_port_sequencer_tb_top;

    localparam int NPORT = 8;
    localparam int CNT_W = 10;
    localparam int PW    = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic [NPORT-1:0] mask_i = '0;
    logic tx_done_i = 1'b0;
    logic [NPORT*CNT_W-1:0] q_count_i;
    logic [NPORT*2-1:0] speed_i;
    logic sel_valid_o, busy_o, done_o;
    logic [PW-1:0] sel_port_o;

    logic [CNT_W-1:0] cnt [NPORT];
    logic [1:0]       spd [NPORT];

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            q_count_i[i*CNT_W +: CNT_W] = cnt[i];
            speed_i[i*2 +: 2]           = spd[i];
        end
    end

    mc_port_sequencer #(.NPORT(NPORT), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .mask_i(mask_i),
        .q_count_i(q_count_i), .speed_i(speed_i), .tx_done_i(tx_done_i),
        .sel_valid_o(sel_valid_o), .sel_port_o(sel_port_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int weight(input int p);
        int sh;
        sh = (spd[p] == 2'd0) ? 6 : (spd[p] == 2'd1) ? 3 : 0;
        return int'(cnt[p]) << sh;
    endfunction

    function automatic int pick(input logic [NPORT-1:0] r);
        logic [NPORT-1:0] e;
        int best, bw;
        e = r;
        e[NPORT-1] = 1'b0;
        if (e == '0) e = r;
        best = -1;
        bw = 0;
        for (int i = 0; i < NPORT; i++)
            if (e[i] && (best < 0 || weight(i) < bw)) begin
                best = i;
                bw = weight(i);
            end
        return best;
    endfunction

    task automatic randomize_counts();
        for (int i = 0; i < NPORT; i++) begin
            cnt[i] = CNT_W'($urandom_range(0, 1023));
            spd[i] = 2'($urandom_range(0, 3));
        end
    endtask

    // Sequence one mask and check every step against the model
    task automatic run_packet(input logic [NPORT-1:0] m, input bit rnd, input bit poke_start);
        logic [NPORT-1:0] r;
        logic [NPORT-1:0] served;
        int exp;
        int waitn;
        r = m;
        served = '0;
        @(negedge clk);
        start_i = 1'b1;
        mask_i = m;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R2 busy after start", int'(busy_o), 1);
        forever begin
            if (r == '0) begin
                @(negedge clk);
                chk(done_o == 1'b1 && sel_valid_o == 1'b0, "R9 done after last", int'(done_o), 1);
                chk(served == m, "R7 every masked port once", int'(served), int'(m));
                break;
            end
            exp = pick(r);
            @(negedge clk);
            chk(sel_valid_o == 1'b1 && int'(sel_port_o) == exp,
                "R2 R6 R3 R4 R8 least congested pick", int'(sel_port_o), exp);
            chk(!served[sel_port_o] && m[sel_port_o], "R7 offered port fresh and in mask",
                int'(sel_port_o), exp);
            served[sel_port_o] = 1'b1;
            r[exp] = 1'b0;
            waitn = $urandom_range(0, 3);
            for (int k = 0; k < waitn; k++) begin
                if (rnd) randomize_counts();
                if (poke_start && k == 0) begin
                    start_i = 1'b1;
                    mask_i = '1;
                end
                @(negedge clk);
                start_i = 1'b0;
                chk(sel_valid_o == 1'b1 && int'(sel_port_o) == exp, "R5 R10 selection held",
                    int'(sel_port_o), exp);
            end
            if (rnd) randomize_counts();
            tx_done_i = 1'b1;
            @(negedge clk);
            tx_done_i = 1'b0;
            chk(sel_valid_o == 1'b0, "R6 valid drops after tx_done", int'(sel_valid_o), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NPORT; i++) begin
            cnt[i] = '0;
            spd[i] = 2'd2;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(!sel_valid_o && !done_o && !busy_o, "R1 reset state", int'(sel_valid_o), 0);

        // R9 empty mask
        run_packet(8'h00, 1'b0, 1'b0);

        // R4 full tie -> ascending order, CPU last
        for (int i = 0; i < NPORT; i++) begin
            cnt[i] = 10'd5;
            spd[i] = 2'd2;
        end
        run_packet(8'hFF, 1'b0, 1'b0);

        // R3 10M count 1 (64) loses to 1G count 60; 100M count 8 (64) ties port0
        cnt[0] = 10'd1;  spd[0] = 2'd0;
        cnt[1] = 10'd60; spd[1] = 2'd2;
        cnt[2] = 10'd8;  spd[2] = 2'd1;
        cnt[3] = 10'd65; spd[3] = 2'd3;
        run_packet(8'h0F, 1'b0, 1'b0);

        // R8 CPU port lightest still last; CPU alone
        cnt[7] = 10'd0; cnt[4] = 10'd900; spd[4] = 2'd0;
        run_packet(8'h90, 1'b0, 1'b0);
        run_packet(8'h80, 1'b0, 1'b0);

        // R10 start while busy ignored
        randomize_counts();
        run_packet(8'h36, 1'b0, 1'b1);

        // R10 tx_done while idle ignored
        @(negedge clk);
        tx_done_i = 1'b1;
        @(negedge clk);
        tx_done_i = 1'b0;
        @(negedge clk);
        chk(done_o && !sel_valid_o && !busy_o, "R10 tx_done idle ignored", int'(busy_o), 0);

        // R6 random masks with counts changing between steps
        for (int n = 0; n < 60; n++) begin
            randomize_counts();
            run_packet(NPORT'($urandom_range(0, 255)), 1'b1, 1'b0);
        end

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule